// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-side controller of a 1024-byte nonvolatile memory model that sits on a two-wire I2C bus. It runs on a fast system clock and oversamples the serial clock and data lines. Each line passes through a synchronizer and a majority vote filter, and start and stop conditions are detected from the filtered lines. The engine checks the incoming device byte and keeps a 10-bit byte pointer. Data bytes it accepts are handed to an external page-buffer block. Bytes to be read come from a synchronous memory port with one cycle of latency. The engine drives the data line only through an open-drain enable, which pulls the line low.

A write transaction has three phases: a device byte with the direction bit clear, one word-address byte, and then one or more data bytes. Each accepted data byte leaves as a staging strobe. A commit strobe follows at the stop condition. While the page buffer reports a write cycle in progress, the engine refuses its device address, so the master can poll for completion. Read transactions cover three cases: a read from the current pointer, a random read built from a word-address phase and a repeated start, and sequential reads that continue for as long as the master acknowledges.

The state machine has ten states:

- `ST_IDLE`: waiting for a start.
- `ST_DEV`: receiving the device byte.
- `ST_DEV_ACK`: the acknowledge slot after the device byte.
- `ST_WADR` and `ST_WADR_ACK`: receiving the word address and its acknowledge slot.
- `ST_WDAT` and `ST_WDAT_ACK`: receiving a data byte and its acknowledge slot.
- `ST_TX`: sending a read byte.
- `ST_TX_ACK`: sampling the master's response to a read byte.
- `ST_IGNORE`: passive until the next start or stop.

The transitions are:

- A stop in any state goes to `ST_IDLE`. A start in any state goes to `ST_DEV`.
- From the eighth bit of a received byte, a falling clock edge moves to the matching acknowledge state. A device byte that does not match, or a data byte refused under write protect, goes to `ST_IGNORE` instead.
- From `ST_DEV_ACK`, the next falling clock edge goes to `ST_TX` for a read and to `ST_WADR` for a write.
- From `ST_WADR_ACK` and from `ST_WDAT_ACK`, the next falling clock edge goes to `ST_WDAT`.
- From `ST_TX`, the eighth falling clock edge goes to `ST_TX_ACK`.
- From `ST_TX_ACK`, a master acknowledge goes back to `ST_TX`. A master not-acknowledge goes to `ST_IGNORE`.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling data line while the filtered clock is high is a start, and a rising data line while the filtered clock is high is a stop. A start in any state restarts device-byte reception, so a repeated start works. A stop in any state returns the engine to idle and releases the data line.
- R2: Bytes move MSB first. The receiver acknowledges by pulling the data line low during the 9th clock. `sda_oe` only ever asserts while the clock line is low, a few system clocks after the clock falls.
- R3: The device byte is acknowledged only when bits 7..4 equal 1010 and bit 3 equals `pin_a2`. Otherwise the engine gives a not-acknowledge and ignores every later byte until the next start.
- R4: Device-byte bits 2..1 load pointer bits 9..8 on every matching device byte. The word-address byte loads pointer bits 7..0.
- R5: In a write, the device byte, the word address and each data byte are acknowledged. Each accepted data byte produces one `wr_stage` pulse carrying the pointer and the byte. A one-cycle `wr_commit` pulse follows the stop only if at least one byte was staged.
- R6: When `wp` is high, the device byte and the word address are still acknowledged. The first data byte gets a not-acknowledge, nothing is staged and no commit follows.
- R7: While `wr_busy` is high the device byte gets a not-acknowledge. Once `wr_busy` is low the same byte is acknowledged.
- R8: A read returns the byte at the pointer and then advances the pointer by one. A current-address read after a write therefore returns the byte after the last one written. Each fetch is a one-cycle `rd_en` pulse.
- R9: In a sequential read, a master acknowledge brings the next byte, and the pointer wraps from 1023 to 0. After a master not-acknowledge the engine releases the data line and waits for a stop.
- R10: During writes the pointer advances only within its 16-byte page: its low four bits wrap and the upper bits stay unchanged.
- R11: After reset `sda_oe`, `wr_stage`, `wr_commit` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |
| pin_a2 | input | 1 | Strap compared with device-byte bit 3 |
| wp | input | 1 | Write protect, high refuses data bytes |
| wr_busy | input | 1 | Internal write cycle in progress |
| wr_stage | output | 1 | One-cycle strobe: stage a data byte |
| wr_addr | output | 10 | Byte address of the staged byte |
| wr_data | output | 8 | Staged byte |
| wr_commit | output | 1 | One-cycle strobe: launch the write cycle |
| rd_en | output | 1 | Read request to the memory port |
| rd_addr | output | 10 | Read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |

## Verification
Two things can land on the same clock edge: the end of an internal write cycle, and the acknowledge decision for a device byte. The bench commits a write and polls with device bytes at once and keeps polling. It checks that the first poll, which lands inside the busy window, gets a not-acknowledge, and that a later poll gets an acknowledge once busy has dropped. The second pairing is the stop that launches a write against the final data byte of a page that has wrapped. The bench judges it from the logged staging addresses and from reading back the wrapped location after the commit.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eei2c_state_e;

    // Fixed device identifier expected in the top nibble of the device byte.
    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/eei2c_line_filter.sv
module eei2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic filt_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = VOTE_LEN / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_LEN-1:0]    win_q;
    logic                   filt_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
            filt_q <= ($countones(win_q) > HALF);
            prev_q <= filt_q;
        end
    end

    assign filt_o = filt_q;
    assign rise_o = filt_q & ~prev_q;
    assign fall_o = ~filt_q & prev_q;

endmodule

// File: rtl/eei2c_bus_cond.sv
module eei2c_bus_cond (
    input  logic scl_f,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // Data may only move while the clock is low; any data edge with the
    // clock high is a bus condition.
    assign start_o = scl_f & sda_fall;
    assign stop_o  = scl_f & sda_rise;
endmodule

// File: rtl/eei2c_sda_hold.sv
module eei2c_sda_hold #(
    parameter int HOLD_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall_i,
    input  logic release_i,
    input  logic drive_i,
    output logic sda_oe_o
);
    localparam int CW = $clog2(HOLD_CLKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sda_oe_o <= 1'b0;
        end else if (release_i) begin
            cnt_q    <= '0;
            sda_oe_o <= 1'b0;
        end else if (scl_fall_i) begin
            cnt_q <= CW'(HOLD_CLKS);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) sda_oe_o <= drive_i;
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eei2c_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3,
    parameter int HOLD_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pin_a2,
    input  logic              wp,
    input  logic              wr_busy,
    output logic              wr_stage,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int BLK_W  = ADDR_W - 8;
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    // Line conditioning: index 1 is the clock, index 0 the data line.
    logic [1:0] raw_w, filt_w, rise_w, fall_w;
    assign raw_w = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        eei2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_LEN(VOTE_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_w[g]),
            .filt_o(filt_w[g]), .rise_o(rise_w[g]), .fall_o(fall_w[g])
        );
    end

    logic scl_rise, scl_fall, sda_f, bus_start, bus_stop;
    assign scl_rise = rise_w[1];
    assign scl_fall = fall_w[1];
    assign sda_f    = filt_w[0];

    eei2c_bus_cond u_cond (
        .scl_f(filt_w[1]), .sda_rise(rise_w[0]), .sda_fall(fall_w[0]),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    eei2c_state_e      state_q, state_nxt;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q, tx_q, txbuf_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              drive_nxt_q, mack_q, staged_q, fetch_pend_q, rd_valid_q;
    logic              dev_match, rx_state, bit_full;

    assign dev_match = (shreg_q[7:4] == DEV_ID) && (shreg_q[3] == pin_a2) && !wr_busy;
    assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WADR) || (state_q == ST_WDAT);
    assign bit_full  = (bitcnt_q == 4'd8);

    eei2c_sda_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .scl_fall_i(scl_fall),
        .release_i(bus_start | bus_stop), .drive_i(drive_nxt_q), .sda_oe_o(sda_oe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        if (bus_stop) begin
            state_nxt = ST_IDLE;
        end else if (bus_start) begin
            state_nxt = ST_DEV;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_DEV:      if (bit_full) state_nxt = dev_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  state_nxt = shreg_q[0] ? ST_TX : ST_WADR;
                ST_WADR:     if (bit_full) state_nxt = ST_WADR_ACK;
                ST_WADR_ACK: state_nxt = ST_WDAT;
                ST_WDAT:     if (bit_full) state_nxt = wp ? ST_IGNORE : ST_WDAT_ACK;
                ST_WDAT_ACK: state_nxt = ST_WDAT;
                ST_TX:       if (bitcnt_q == 4'd7) state_nxt = ST_TX_ACK;
                ST_TX_ACK:   state_nxt = mack_q ? ST_TX : ST_IGNORE;
                ST_IDLE, ST_IGNORE: state_nxt = state_q;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q     <= '0;
            shreg_q      <= '0;
            tx_q         <= '0;
            txbuf_q      <= '0;
            ptr_q        <= '0;
            drive_nxt_q  <= 1'b0;
            mack_q       <= 1'b0;
            staged_q     <= 1'b0;
            fetch_pend_q <= 1'b0;
            rd_valid_q   <= 1'b0;
            wr_stage     <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            wr_commit    <= 1'b0;
            rd_en        <= 1'b0;
            rd_addr      <= '0;
        end else begin
            wr_stage   <= 1'b0;
            wr_commit  <= 1'b0;
            rd_en      <= 1'b0;
            rd_valid_q <= rd_en;
            if (rd_valid_q) txbuf_q <= rd_data;
            if (fetch_pend_q) begin
                rd_en        <= 1'b1;
                rd_addr      <= ptr_q;
                fetch_pend_q <= 1'b0;
            end
            if (bus_stop) begin
                wr_commit   <= staged_q;
                staged_q    <= 1'b0;
                bitcnt_q    <= '0;
                drive_nxt_q <= 1'b0;
            end else if (bus_start) begin
                staged_q    <= 1'b0;
                bitcnt_q    <= '0;
                drive_nxt_q <= 1'b0;
            end else begin
                if (scl_rise && rx_state) begin
                    shreg_q  <= {shreg_q[6:0], sda_f};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
                if (scl_rise && state_q == ST_TX_ACK) begin
                    mack_q <= !sda_f;
                    if (!sda_f) fetch_pend_q <= 1'b1;
                end
                if (scl_fall) begin
                    case (state_q)
                        ST_DEV: if (bit_full) begin
                            bitcnt_q    <= '0;
                            drive_nxt_q <= dev_match;
                            if (dev_match) begin
                                ptr_q <= {shreg_q[BLK_W:1], ptr_q[7:0]};
                                if (shreg_q[0]) fetch_pend_q <= 1'b1;
                            end
                        end
                        ST_DEV_ACK: begin
                            bitcnt_q <= '0;
                            if (shreg_q[0]) begin
                                tx_q        <= txbuf_q;
                                ptr_q       <= ptr_q + 1'b1;
                                drive_nxt_q <= !txbuf_q[7];
                            end else begin
                                drive_nxt_q <= 1'b0;
                            end
                        end
                        ST_WADR: if (bit_full) begin
                            bitcnt_q    <= '0;
                            ptr_q[7:0]  <= shreg_q;
                            drive_nxt_q <= 1'b1;
                        end
                        ST_WDAT: if (bit_full) begin
                            bitcnt_q    <= '0;
                            drive_nxt_q <= !wp;
                            if (!wp) begin
                                wr_stage <= 1'b1;
                                wr_addr  <= ptr_q;
                                wr_data  <= shreg_q;
                                staged_q <= 1'b1;
                                ptr_q    <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                            end
                        end
                        ST_TX: begin
                            if (bitcnt_q == 4'd7) begin
                                bitcnt_q    <= '0;
                                drive_nxt_q <= 1'b0;
                            end else begin
                                bitcnt_q    <= bitcnt_q + 1'b1;
                                tx_q        <= {tx_q[6:0], 1'b0};
                                drive_nxt_q <= !tx_q[6];
                            end
                        end
                        ST_TX_ACK: begin
                            if (mack_q) begin
                                tx_q        <= txbuf_q;
                                ptr_q       <= ptr_q + 1'b1;
                                drive_nxt_q <= !txbuf_q[7];
                            end else begin
                                drive_nxt_q <= 1'b0;
                            end
                        end
                        default: drive_nxt_q <= 1'b0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic wp,
    input logic sda_oe,
    input logic wr_stage,
    input logic wr_commit,
    input logic rd_en
);
    // R2: the pull-down only engages while the clock line is low
    p_oe_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R6: no byte is staged while write protect is held
    p_stage_unprotected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stage |-> !$past(wp));

    // R5: the commit strobe lasts one cycle
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R8: each fetch is a single-cycle request
    p_fetch_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R5: staging and commit never coincide
    p_stage_commit_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !wr_stage);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp(wp), .sda_oe(sda_oe),
    .wr_stage(wr_stage), .wr_commit(wr_commit), .rd_en(rd_en)
);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, sda_bus;
    logic wp = 1'b0, busy;
    logic wr_stage, wr_commit, rd_en;
    logic [9:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    assign sda_bus = m_sda & ~sda_oe;

    eeprom_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .pin_a2(1'b1), .wp(wp), .wr_busy(busy),
        .wr_stage(wr_stage), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, failures = 0;
    logic [7:0] mem [1024];
    logic [9:0] pend_a [64];
    logic [7:0] pend_d [64];
    logic [9:0] log_a [16];
    logic [7:0] log_d [16];
    int pend_n = 0, log_n = 0, commit_n = 0, busy_cnt = 0, oe_bad = 0;
    logic oe_prev = 1'b0;

    assign busy = (busy_cnt != 0);

    function automatic logic [7:0] seed(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Page-buffer and memory model
    always @(posedge clk) begin
        if (wr_stage) begin
            pend_a[pend_n] = wr_addr;
            pend_d[pend_n] = wr_data;
            pend_n++;
            if (log_n < 16) begin
                log_a[log_n] = wr_addr;
                log_d[log_n] = wr_data;
            end
            log_n++;
        end
        if (wr_commit) begin
            for (int i = 0; i < pend_n; i++) mem[pend_a[i]] = pend_d[i];
            pend_n = 0;
            commit_n++;
            busy_cnt = 2000;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // R2 monitor: pull-down must never engage with the clock high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && m_scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; w(20);
        m_scl = 1'b1; w(40);
        m_sda = 1'b0; w(40);
        m_scl = 1'b0; w(20);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; w(20);
        m_scl = 1'b1; w(40);
        m_sda = 1'b1; w(40);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(20);
            m_scl = 1'b1; w(40);
            m_scl = 1'b0; w(20);
        end
        m_sda = 1'b1; w(20);
        m_scl = 1'b1; w(20);
        ack = !sda_bus; w(20);
        m_scl = 1'b0; w(20);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; w(20);
            m_scl = 1'b1; w(20);
            b = {b[6:0], sda_bus}; w(20);
            m_scl = 1'b0; w(20);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; w(20);
        m_scl = 1'b1; w(40);
        m_scl = 1'b0; w(20);
        m_sda = 1'b1;
    endtask

    task automatic rand_read_setup(input logic [1:0] blk, input logic [7:0] word);
        logic a;
        i2c_start();
        send_byte({4'b1010, 1'b1, blk, 1'b0}, a);
        chk(a, "R4 device ack", a, 1);
        send_byte(word, a);
        chk(a, "R4 word ack", a, 1);
        i2c_start();
        send_byte({4'b1010, 1'b1, blk, 1'b1}, a);
        chk(a, "R1 repeated-start ack", a, 1);
    endtask

    task automatic wait_ready();
        logic a;
        a = 1'b0;
        for (int t = 0; t < 10 && !a; t++) begin
            w(200);
            i2c_start();
            send_byte(8'hAC, a);
            i2c_stop();
        end
        chk(a, "R7 ready ack", a, 1);
    endtask

    initial begin : main
        logic a, a1, a2, a3;
        logic [7:0] b, b0, b1, b2;
        int c0;
        for (int i = 0; i < 1024; i++) mem[i] = seed(i);
        w(10);
        rst_n = 1'b1;
        w(5);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
        chk(!wr_stage && !wr_commit && !rd_en, "R11 strobes", {wr_stage, wr_commit, rd_en}, 0);

        // R3 sweep over identifier nibble and strap bit
        for (int id = 0; id < 16; id++) begin
            for (int s = 0; s < 2; s++) begin
                i2c_start();
                send_byte({4'(id), 1'(s), 3'b000}, a);
                i2c_stop();
                chk(a == ((id == 10) && (s == 1)), "R3 device match", a, (id == 10) && (s == 1));
            end
        end
        // R3 ignore until next start, even for a valid device byte
        i2c_start();
        send_byte(8'hB8, a);
        send_byte(8'hA8, a1);
        i2c_stop();
        chk(!a && !a1, "R3 ignore after mismatch", {a, a1}, 0);

        // R5 byte write
        log_n = 0;
        i2c_start();
        send_byte(8'hAA, a1);
        send_byte(8'h20, a2);
        send_byte(8'h5A, a3);
        i2c_stop();
        w(5);
        chk(a1 && a2 && a3, "R5 write acks", {a1, a2, a3}, 7);
        chk(log_n == 1, "R5 stage count", log_n, 1);
        chk(log_a[0] == 10'h120 && log_d[0] == 8'h5A, "R5 stage addr/data", {log_a[0], log_d[0]}, {10'h120, 8'h5A});
        chk(commit_n == 1, "R5 commit", commit_n, 1);

        // R7 busy polling
        i2c_start();
        send_byte(8'hAA, a);
        i2c_stop();
        chk(!a, "R7 nack while busy", a, 0);
        wait_ready();

        // R8 current-address read follows last write
        i2c_start();
        send_byte(8'hAB, a);
        recv_byte(b, 1'b0);
        i2c_stop();
        chk(a, "R8 read device ack", a, 1);
        chk(b == seed(16'h121), "R8 current read", b, seed(16'h121));

        // R1 / R4 random read
        rand_read_setup(2'd1, 8'h20);
        recv_byte(b, 1'b0);
        i2c_stop();
        chk(b == 8'h5A, "R4 random read", b, 8'h5A);

        // R9 sequential read across the top of memory
        rand_read_setup(2'd3, 8'hFE);
        recv_byte(b0, 1'b1);
        recv_byte(b1, 1'b1);
        recv_byte(b2, 1'b0);
        chk(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
        i2c_stop();
        chk(b0 == seed(16'h3FE), "R9 byte 3FE", b0, seed(16'h3FE));
        chk(b1 == seed(16'h3FF), "R9 byte 3FF", b1, seed(16'h3FF));
        chk(b2 == seed(0), "R9 wrap to 0", b2, seed(0));
        chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

        // R10 page wrap on writes
        log_n = 0;
        i2c_start();
        send_byte(8'hAC, a);
        send_byte(8'h3E, a);
        send_byte(8'h11, a1);
        send_byte(8'h22, a2);
        send_byte(8'h33, a3);
        i2c_stop();
        chk(log_n == 3, "R10 stage count", log_n, 3);
        chk(log_a[0] == 10'h23E && log_a[1] == 10'h23F && log_a[2] == 10'h230,
            "R10 page wrap", log_a[2], 10'h230);
        wait_ready();
        rand_read_setup(2'd2, 8'h30);
        recv_byte(b, 1'b0);
        i2c_stop();
        chk(b == 8'h33, "R10 wrapped byte", b, 8'h33);

        // R6 write protect
        wp = 1'b1;
        log_n = 0;
        c0 = commit_n;
        i2c_start();
        send_byte(8'hAC, a1);
        send_byte(8'h50, a2);
        send_byte(8'h99, a3);
        i2c_stop();
        w(5);
        chk(a1 && a2, "R6 address acks", {a1, a2}, 3);
        chk(!a3, "R6 data nack", a3, 0);
        chk(log_n == 0 && commit_n == c0, "R6 no stage/commit", log_n, 0);
        wp = 1'b0;
        i2c_start();
        send_byte(8'hAC, a);
        i2c_stop();
        chk(a, "R6 not busy after refused write", a, 1);
        rand_read_setup(2'd2, 8'h50);
        recv_byte(b, 1'b0);
        i2c_stop();
        chk(b == seed(16'h250), "R6 memory unchanged", b, seed(16'h250));

        // R2 drive timing over the whole run
        chk(oe_bad == 0, "R2 drive only with clock low", oe_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule